// File: doc/BRIEF.md
# Translation Buffer with Hardware Refill

This block translates virtual addresses into physical addresses through a small, fully associative set of cached page-table entries. Each request gives a virtual address and an access type, read or write. When a cached entry matches the page number, is valid and permits the access, the block answers one cycle later. The answer is the entry's frame number joined to the untouched page offset.

When the lookup fails, a built-in walker reads the entry for the page from a single-level page table through a simple memory port. If that entry is valid, the walker installs it and repeats the access. If it is not valid, the walker reports a page fault carrying the faulting address. Before a new entry overwrites an occupied slot, a dirty occupant is written back to its page-table word. New requests stall while the walker is active. A flush input drops every cached entry at once and writes nothing back.

Top module: `tlb_refill`

## Requirements
- R1: A page-table word is 32 bits. Bit 0 is valid, bit 1 is dirty, bit 2 permits reads, bit 3 permits writes, and bits 31:12 hold the frame number. The word for page number P is read at address `pt_base + 4*P`.
- R2: An accepted request hits when a cached entry is valid, has a matching page number and permits the access. The result is then `rsp_valid` for one cycle on the following clock, with `rsp_paddr = {frame, vaddr[11:0]}`, and no memory access takes place.
- R3: A request that misses causes one page-table read. If the fetched word has bit 0 set, the word is cached and the access is repeated, and the response arrives as in R2.
- R4: If the fetched word has bit 0 clear, `fault_valid` pulses for one cycle with `fault_vaddr` equal to the request address, and nothing is cached. A repeat of the same access therefore reads the page table again.
- R5: The slot for a new entry is chosen in this order: a valid slot holding the same page number; otherwise the lowest-numbered empty slot; otherwise the slot at a round-robin pointer. The pointer starts at 0 and advances by one only when it was used.
- R6: If the chosen slot holds a valid dirty entry, that entry's word (with bit 1 set) is written to its own page-table address before the new entry is installed. A clean slot causes no write.
- R7: A write hit sets the dirty bit in the cached entry only. It causes no memory write.
- R8: If the repeated access after a refill is still not permitted, `deny_valid` pulses for one cycle with `fault_vaddr` equal to the request address.
- R9: `req_ready` is low while the walker is busy. A memory request holds its address and direction until `mem_ack`.
- R10: `flush` invalidates every cached entry without any memory write. The next access to a previously cached page misses.
- R11: After reset, `req_ready` is high and `rsp_valid`, `fault_valid`, `deny_valid` and `mem_req` are low.
- R12: At most one of `rsp_valid`, `fault_valid` and `deny_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached entries |
| pt_base | input | PA_W | Page-table base address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_paddr | output | PA_W | Physical address |
| fault_valid | output | 1 | Page fault pulse (fetched entry invalid) |
| deny_valid | output | 1 | Access refused after refill |
| fault_vaddr | output | VA_W | Address of the faulting or refused access |
| mem_req | output | 1 | Page-table memory request |
| mem_we | output | 1 | 1 = write-back, 0 = entry fetch |
| mem_addr | output | PA_W | Page-table word address |
| mem_wdata | output | PTE_W | Word written back |
| mem_rdata | input | PTE_W | Word read, valid with mem_ack |
| mem_ack | input | 1 | Memory request completes |

## Verification
Several rules are checked on every cycle: the stall of new requests during a walk, a memory request that stays stable until acknowledged, the one-cycle width of the fault and refusal pulses, the exclusiveness of the three outcomes, and the preservation of the page offset on a one-cycle hit. Other behaviours need a sequence of accesses with known page-table contents and can only be shown by the bench's scenarios. These are the slot-choice order across empty, matching and round-robin slots, the timing and contents of a dirty write-back, the dirty bit staying inside the cache, faults that install nothing, and a flush that forces later misses.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // Flag positions inside a page-table word (frame number sits in the top bits)
   localparam int PTE_VALID = 0;
   localparam int PTE_DIRTY = 1;
   localparam int PTE_RD    = 2;
   localparam int PTE_WR    = 3;
   localparam int PTE_FLAGS = 4;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_WBACK,
      ST_RETRY
   } walk_state_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20
) (
   input  logic [VPN_W-1:0]                vpn,
   input  logic [ENTRIES-1:0]              ent_v,
   input  logic [ENTRIES-1:0][VPN_W-1:0]   ent_vpn,
   output logic [ENTRIES-1:0]              match_vec,
   output logic                            match_any,
   output logic [$clog2(ENTRIES)-1:0]      match_idx
);
   localparam int IDX_W = $clog2(ENTRIES);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = ent_v[g] && (ent_vpn[g] == vpn);
   end

   assign match_any = |match_vec;

   always_comb begin
      match_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_vec[i]) match_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int ENTRIES     = 8,
   parameter bit EMPTY_FIRST = 1'b1
) (
   input  logic [ENTRIES-1:0]          ent_v,
   input  logic [ENTRIES-1:0]          match_vec,
   input  logic [$clog2(ENTRIES)-1:0]  rr_ptr,
   output logic [$clog2(ENTRIES)-1:0]  victim_idx,
   output logic                        take_rr
);
   localparam int IDX_W = $clog2(ENTRIES);

   logic             has_match;
   logic [IDX_W-1:0] m_idx;

   always_comb begin
      has_match = 1'b0;
      m_idx     = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_vec[i]) begin
            has_match = 1'b1;
            m_idx     = IDX_W'(i);
         end
      end
   end

   if (EMPTY_FIRST) begin : g_empty_first
      logic             has_empty;
      logic [IDX_W-1:0] e_idx;
      always_comb begin
         has_empty = 1'b0;
         e_idx     = '0;
         for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_v[i]) begin
               has_empty = 1'b1;
               e_idx     = IDX_W'(i);
            end
         end
      end
      assign take_rr    = !has_match && !has_empty;
      assign victim_idx = has_match ? m_idx : (has_empty ? e_idx : rr_ptr);
   end else begin : g_rr_only
      logic unused_v;
      assign unused_v   = ^ent_v;
      assign take_rr    = !has_match;
      assign victim_idx = has_match ? m_idx : rr_ptr;
   end
endmodule

// File: rtl/tlb_refill.sv
module tlb_refill
   import tlb_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int PAGE_BITS   = 12,
   parameter int ENTRIES     = 8,
   parameter int PTE_W       = 32,
   parameter bit EMPTY_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [PA_W-1:0]   pt_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [VA_W-1:0]   req_vaddr,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              fault_valid,
   output logic              deny_valid,
   output logic [VA_W-1:0]   fault_vaddr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PA_W-1:0]   mem_addr,
   output logic [PTE_W-1:0]  mem_wdata,
   input  logic [PTE_W-1:0]  mem_rdata,
   input  logic              mem_ack
);
   localparam int VPN_W     = VA_W - PAGE_BITS;
   localparam int FRAME_W   = PA_W - PAGE_BITS;
   localparam int IDX_W     = $clog2(ENTRIES);
   localparam int PTE_SHIFT = $clog2(PTE_W / 8);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (PTE_W < FRAME_W + PTE_FLAGS || (PTE_W % 8) != 0) begin : g_bad_pte
      $error("PTE_W must be whole bytes and hold the frame and flag bits");
   end
   if (VA_W <= PAGE_BITS || PA_W <= PAGE_BITS) begin : g_bad_page
      $error("address widths must exceed PAGE_BITS");
   end

   walk_state_t                       state_q;
   logic [VA_W-1:0]                   vaddr_q;
   logic                              wr_q;
   logic [IDX_W-1:0]                  vic_q, rr_q;
   logic [PTE_W-1:0]                  new_pte_q;
   logic [ENTRIES-1:0]                ent_v;
   logic [ENTRIES-1:0][VPN_W-1:0]     ent_vpn;
   logic [ENTRIES-1:0][PTE_W-1:0]     ent_pte;

   logic [VA_W-1:0]    look_vaddr;
   logic               look_wr;
   logic [ENTRIES-1:0] match_vec;
   logic               match_any;
   logic [IDX_W-1:0]   match_idx;
   logic [PTE_W-1:0]   sel_pte;
   logic               hit;
   logic [IDX_W-1:0]   victim_idx;
   logic               take_rr;
   logic               wb_needed;
   logic               do_hit;
   logic [VPN_W-1:0]   mem_vpn;

   assign req_ready  = (state_q == ST_IDLE);
   assign look_vaddr = req_ready ? req_vaddr : vaddr_q;
   assign look_wr    = req_ready ? req_write : wr_q;

   tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
      .vpn       (look_vaddr[VA_W-1:PAGE_BITS]),
      .ent_v     (ent_v),
      .ent_vpn   (ent_vpn),
      .match_vec (match_vec),
      .match_any (match_any),
      .match_idx (match_idx)
   );

   tlb_victim #(.ENTRIES(ENTRIES), .EMPTY_FIRST(EMPTY_FIRST)) u_victim (
      .ent_v      (ent_v),
      .match_vec  (match_vec),
      .rr_ptr     (rr_q),
      .victim_idx (victim_idx),
      .take_rr    (take_rr)
   );

   assign sel_pte   = ent_pte[match_idx];
   assign hit       = match_any && (look_wr ? sel_pte[PTE_WR] : sel_pte[PTE_RD]);
   assign wb_needed = ent_v[victim_idx] && ent_pte[victim_idx][PTE_DIRTY];
   assign do_hit    = hit && ((req_ready && req_valid) || state_q == ST_RETRY);

   assign mem_req   = (state_q == ST_FETCH) || (state_q == ST_WBACK);
   assign mem_we    = (state_q == ST_WBACK);
   assign mem_vpn   = mem_we ? ent_vpn[vic_q] : vaddr_q[VA_W-1:PAGE_BITS];
   assign mem_addr  = pt_base + (PA_W'(mem_vpn) << PTE_SHIFT);
   assign mem_wdata = ent_pte[vic_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         vaddr_q     <= '0;
         wr_q        <= 1'b0;
         vic_q       <= '0;
         rr_q        <= '0;
         new_pte_q   <= '0;
         ent_v       <= '0;
         ent_vpn     <= '0;
         ent_pte     <= '0;
         rsp_valid   <= 1'b0;
         rsp_paddr   <= '0;
         fault_valid <= 1'b0;
         deny_valid  <= 1'b0;
         fault_vaddr <= '0;
      end else begin
         rsp_valid   <= 1'b0;
         fault_valid <= 1'b0;
         deny_valid  <= 1'b0;

         if (do_hit) begin
            rsp_valid <= 1'b1;
            rsp_paddr <= {sel_pte[PTE_W-1 -: FRAME_W], look_vaddr[PAGE_BITS-1:0]};
            if (look_wr) ent_pte[match_idx][PTE_DIRTY] <= 1'b1;
         end

         case (state_q)
            ST_IDLE: begin
               if (req_valid && !hit) begin
                  vaddr_q <= req_vaddr;
                  wr_q    <= req_write;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  if (mem_rdata[PTE_VALID]) begin
                     vic_q <= victim_idx;
                     if (take_rr) rr_q <= rr_q + 1'b1;
                     if (wb_needed) begin
                        new_pte_q <= mem_rdata;
                        state_q   <= ST_WBACK;
                     end else begin
                        ent_v[victim_idx]   <= 1'b1;
                        ent_vpn[victim_idx] <= vaddr_q[VA_W-1:PAGE_BITS];
                        ent_pte[victim_idx] <= mem_rdata;
                        state_q             <= ST_RETRY;
                     end
                  end else begin
                     fault_valid <= 1'b1;
                     fault_vaddr <= vaddr_q;
                     state_q     <= ST_IDLE;
                  end
               end
            end
            ST_WBACK: begin
               if (mem_ack) begin
                  ent_v[vic_q]   <= 1'b1;
                  ent_vpn[vic_q] <= vaddr_q[VA_W-1:PAGE_BITS];
                  ent_pte[vic_q] <= new_pte_q;
                  state_q        <= ST_RETRY;
               end
            end
            default: begin
               if (!hit) begin
                  deny_valid  <= 1'b1;
                  fault_vaddr <= vaddr_q;
               end
               state_q <= ST_IDLE;
            end
         endcase

         if (flush) ent_v <= '0;
      end
   end
endmodule

// File: rtl/tlb_refill_chk.sv
module tlb_refill_chk #(
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_ready,
   input logic [PAGE_BITS-1:0] req_off,
   input logic                 rsp_valid,
   input logic [PAGE_BITS-1:0] rsp_off,
   input logic                 fault_valid,
   input logic                 deny_valid,
   input logic                 mem_req,
   input logic                 mem_we,
   input logic [PA_W-1:0]      mem_addr,
   input logic                 mem_ack
);
   // R9
   walk_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   // R9
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R12
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_valid, fault_valid, deny_valid}));

   // R2
   offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_valid && req_ready)) |-> (rsp_off == $past(req_off)));

   // R4
   fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |=> !fault_valid);

   // R8
   deny_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deny_valid |=> !deny_valid);
endmodule

bind tlb_refill tlb_refill_chk #(.PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_off     (req_vaddr[PAGE_BITS-1:0]),
   .rsp_valid   (rsp_valid),
   .rsp_off     (rsp_paddr[PAGE_BITS-1:0]),
   .fault_valid (fault_valid),
   .deny_valid  (deny_valid),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .mem_ack     (mem_ack)
);

// File: tb/test_tlb_refill.sv
`timescale 1ns/1ps
module test_tlb_refill;
   localparam logic [31:0] BASE = 32'h0004_0000;

   logic        clk = 1'b0;
   logic        rst_n, flush, req_valid, req_write, mem_ack;
   logic [31:0] pt_base, req_vaddr, mem_rdata;
   logic        req_ready, rsp_valid, fault_valid, deny_valid, mem_req, mem_we;
   logic [31:0] rsp_paddr, fault_vaddr, mem_addr, mem_wdata;

   tlb_refill i_tlb_refill (
      .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .fault_valid(fault_valid), .deny_valid(deny_valid), .fault_vaddr(fault_vaddr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   always #5 clk = ~clk;

   typedef struct { int kind; logic [31:0] val; string tag; } exp_t;
   typedef struct { logic [31:0] addr; logic [31:0] data; } wb_t;
   exp_t exp_q[$];
   wb_t  wb_q[$];

   int checks = 0, fails = 0, rd_cnt = 0, wr_cnt = 0;
   bit ready_viol = 1'b0;
   logic [31:0] pt_mem [0:63];

   function automatic logic [31:0] mk_pte(int frame, bit r, bit w, bit v);
      return {frame[19:0], 8'h00, w, r, 1'b0, v};
   endfunction

   function automatic logic [31:0] va(int vpn, int off);
      return {vpn[19:0], off[11:0]};
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exv);
      end
   endtask

   // page-table memory model, acknowledges one cycle after a request appears
   initial begin
      mem_ack   = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_ack) mem_ack = 1'b0;
         else if (mem_req) begin
            logic [5:0] idx;
            idx = 6'((mem_addr - BASE) >> 2);
            if (req_ready) ready_viol = 1'b1;
            if (mem_we) begin
               wr_cnt++;
               if (wb_q.size() == 0) chk(1'b0, "R6 unexpected write-back", mem_addr, 32'h0);
               else begin
                  wb_t w;
                  w = wb_q.pop_front();
                  chk(mem_addr == w.addr, "R1 R6 write-back address", mem_addr, w.addr);
                  chk(mem_wdata == w.data, "R6 write-back word", mem_wdata, w.data);
               end
               pt_mem[idx] = mem_wdata;
            end else begin
               rd_cnt++;
               mem_rdata = pt_mem[idx];
            end
            mem_ack = 1'b1;
         end
      end
   end

   // scoreboard monitor: kind 0 = response, 1 = page fault, 2 = refusal
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            int n;
            n = int'(rsp_valid) + int'(fault_valid) + int'(deny_valid);
            if (n > 1) chk(1'b0, "R12 several outcomes at once", 32'(n), 32'd1);
            if (n >= 1) begin
               int k;
               logic [31:0] v;
               k = rsp_valid ? 0 : (fault_valid ? 1 : 2);
               v = rsp_valid ? rsp_paddr : fault_vaddr;
               if (exp_q.size() == 0) chk(1'b0, "unexpected outcome", v, 32'h0);
               else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  chk(k == e.kind, {e.tag, " kind"}, 32'(k), 32'(e.kind));
                  chk(v == e.val, e.tag, v, e.val);
               end
            end
         end
      end
   end

   task automatic access(int vpn, int off, bit wr, int kind, logic [31:0] val, string tag);
      exp_q.push_back('{kind, val, tag});
      @(negedge clk);
      req_vaddr = va(vpn, off);
      req_write = wr;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   task automatic rd_ok(int vpn, int off, string tag);
      access(vpn, off, 1'b0, 0, {20'(32'h80 + vpn), off[11:0]}, tag);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_vaddr = '0; pt_base = BASE;
      for (int k = 0; k < 64; k++) pt_mem[k] = mk_pte(32'h80 + k, 1'b1, 1'b1, 1'b1);
      pt_mem[20] = mk_pte(32'h94, 1'b1, 1'b1, 1'b0);
      pt_mem[21] = mk_pte(32'h95, 1'b1, 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R11 ready after reset", 32'(req_ready), 32'd1);
      chk(!rsp_valid && !fault_valid && !deny_valid, "R11 outcomes idle",
          {29'd0, rsp_valid, fault_valid, deny_valid}, 32'd0);
      chk(mem_req == 1'b0, "R11 no memory request", 32'(mem_req), 32'd0);
      rst_n = 1'b1;

      rd_ok(1, 32'h123, "R1 R3 refill read vpn1");
      chk(rd_cnt == 1, "R3 one table read", 32'(rd_cnt), 32'd1);
      rd_ok(1, 32'habc, "R2 hit vpn1");
      chk(rd_cnt == 1, "R2 hit without memory", 32'(rd_cnt), 32'd1);
      access(2, 32'h010, 1'b1, 0, {20'h82, 12'h010}, "R3 refill write vpn2");
      access(2, 32'hff0, 1'b1, 0, {20'h82, 12'hff0}, "R2 write hit vpn2");
      chk(wr_cnt == 0, "R7 dirty kept in cache", 32'(wr_cnt), 32'd0);
      chk(rd_cnt == 2, "R7 write hit no read", 32'(rd_cnt), 32'd2);
      for (int p = 3; p <= 8; p++) rd_ok(p, 32'h004 * p, "R5 fill empty slots");
      chk(rd_cnt == 8, "R5 eight refills", 32'(rd_cnt), 32'd8);
      rd_ok(9, 32'h777, "R5 first round-robin victim");
      chk(wr_cnt == 0, "R6 clean victim no write", 32'(wr_cnt), 32'd0);
      wb_q.push_back('{BASE + 32'd8, mk_pte(32'h82, 1'b1, 1'b1, 1'b1) | 32'h2});
      rd_ok(10, 32'h001, "R6 refill over dirty vpn2");
      chk(wr_cnt == 1, "R6 one write-back", 32'(wr_cnt), 32'd1);
      rd_ok(1, 32'h321, "R5 vpn1 evicted earlier");
      chk(rd_cnt == 11, "R5 vpn1 refetched", 32'(rd_cnt), 32'd11);
      rd_ok(4, 32'h444, "R5 pointer kept vpn4");
      chk(rd_cnt == 11, "R5 vpn4 still cached", 32'(rd_cnt), 32'd11);

      access(20, 32'h050, 1'b0, 1, va(20, 32'h050), "R4 page fault");
      access(20, 32'h060, 1'b0, 1, va(20, 32'h060), "R4 repeat fault");
      chk(rd_cnt == 13, "R4 nothing installed", 32'(rd_cnt), 32'd13);

      access(21, 32'h0aa, 1'b0, 0, {20'h95, 12'h0aa}, "R3 read-only refill");
      access(21, 32'h0bb, 1'b1, 2, va(21, 32'h0bb), "R8 write refused");
      chk(rd_cnt == 15, "R8 refetch on refused write", 32'(rd_cnt), 32'd15);
      rd_ok(5, 32'h555, "R5 matching slot reused");
      chk(rd_cnt == 15, "R5 vpn5 untouched", 32'(rd_cnt), 32'd15);

      access(5, 32'h556, 1'b1, 0, {20'h85, 12'h556}, "R7 write hit vpn5");
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      rd_ok(5, 32'h557, "R10 miss after flush");
      rd_ok(6, 32'h668, "R10 second miss after flush");
      chk(rd_cnt == 17, "R10 flush forced refills", 32'(rd_cnt), 32'd17);
      chk(wr_cnt == 1, "R10 flush wrote nothing", 32'(wr_cnt), 32'd1);

      chk(!ready_viol, "R9 ready low during walks", 32'(ready_viol), 32'd0);
      chk(wb_q.size() == 0, "R6 all write-backs seen", 32'(wb_q.size()), 32'd0);
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule